// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address by searching a hashed page table held in ordinary memory. A translation request carries the address and two qualifiers: whether the access is a store and whether it is an instruction fetch. The walker derives a hash from the page number and the segment nibble. It uses a latched table configuration word (base address plus size field) to locate an eight-entry group, and it reads the compare word of each entry in turn. If the first group holds no match, the walker searches a second group found through the complemented hash, this time looking for compare words with the secondary flag set.

On a hit the walker reads the entry's second word and checks protection. If the access is allowed, it writes that word back with the referenced bit set, and with the changed bit also set for a store. It then returns the page frame joined with the page offset. A failed search or a forbidden access ends in a one-cycle response that carries a fault flag and a status word.

The request side is valid/ready. A request is taken when both are high, and the ready output then stays low until the response pulse, so only one translation is ever in flight. The response is a one-cycle pulse with no back-pressure. The memory side holds one access at a time: the walker keeps its valid, address, write enable and write data steady until the memory raises ready for one cycle, and read data is taken in that same cycle.

Top module: `hpw_walker`

## Requirements
- R1: The primary hash is `(EA[27:12] XOR EA[31:28]) & 0x7FFFF`. The group base is `{CFG[31:9],9'b0} | ((hash << 6) & ({CFG[8:0],16'h0} | 0xFFC0))`. Compare words are read at group base + 8*i, for i from 0 upward.
- R2: An entry matches when its compare word equals `0x80000000 | EA[31:28]<<7 | H<<6 | EA[27:22]`, where H is 0 in the first pass and 1 in the second. The lowest matching entry in the group wins, and no further compare words are read.
- R3: After eight misses in the primary group, the walker searches the group given by `~hash & 0x7FFFF` with H = 1.
- R4: After eight misses in the secondary group, the response carries fault = 1 and status code 0x40000000, and nothing is written to memory.
- R5: On an allowed hit, the walker writes the entry's second word (at the compare word address + 4) back with bit 8 (0x100) set, and also with bit 7 (0x80) set when the access is a store.
- R6: A successful response carries fault = 0, status = 0, and physical address `{word2[31:12], EA[11:0]}`.
- R7: An instruction fetch from an entry whose second word has bit 3 (0x8) set ends with fault = 1 and status code 0x08000000, and nothing is written.
- R8: A store to an entry whose second word has bits 1:0 equal to 11 is a protection fault (0x08000000) with no write. A load from the same entry succeeds.
- R9: Every fault raised by a store also sets status bit 25 (0x02000000).
- R10: From acceptance until the response, req_ready is low. rsp_valid is high for exactly one cycle per request.
- R11: The memory request stays asserted with a stable address and write enable until mem_ready. The walker raises no memory request while idle.
- R12: A nonzero size field CFG[8:0] lets hash bits 10 and above select the group (for example, CFG[0] brings hash bit 10 in at address bit 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| table_cfg | input | 32 | Table base (bits 31:9) and size field (bits 8:0), latched on request acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | High only when idle |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_pa | output | 32 | Physical address (0 on a fault) |
| rsp_status | output | 32 | Fault status word (0 on success) |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong hash, pass flag or entry counter shows first on mem_addr, at the very first compare read of a walk. The bench therefore records the address of the first read and counts the reads of every translation. A stale match or protection decision shows up in the response within one memory access: either a write that should not appear in the bench's memory, or a missing referenced or changed bit in it. A sequencing fault such as a lost response or a reopened ready shows within a cycle at the request handshake.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam logic [31:0] ST_NOTFOUND = 32'h4000_0000;
  localparam logic [31:0] ST_PROT     = 32'h0800_0000;
  localparam logic [31:0] ST_STORE    = 32'h0200_0000;
  localparam logic [31:0] BIT_REF     = 32'h0000_0100;
  localparam logic [31:0] BIT_CHG     = 32'h0000_0080;
  localparam logic [31:0] BIT_GUARD   = 32'h0000_0008;

  typedef enum logic [2:0] {
    S_IDLE, S_CMP, S_WORD, S_WB, S_RESP
  } walk_state_t;
endpackage

// File: rtl/hpw_hash.sv
// Group and compare-word generation for one pass of the search.
module hpw_hash #(
  parameter int IDX_W       = 3,
  parameter int ENTRY_BYTES = 8
) (
  input  logic [31:12]     vpn,
  input  logic [31:0]      cfg,
  input  logic             secondary,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      entry_addr,
  output logic [31:0]      cmp_word
);
  localparam int SH = $clog2(ENTRY_BYTES);

  logic [18:0] hash_pri, hash_sel;
  logic [31:0] mask, group;

  always_comb begin
    hash_pri   = {3'b000, vpn[27:12] ^ {12'h000, vpn[31:28]}};
    hash_sel   = secondary ? ~hash_pri : hash_pri;
    mask       = {7'd0, cfg[8:0], 16'hFFC0};
    group      = {cfg[31:9], 9'd0} | ({7'd0, hash_sel, 6'd0} & mask);
    entry_addr = group + ({{(32-IDX_W){1'b0}}, idx} << SH);
    cmp_word   = {1'b1, 20'd0, vpn[31:28], secondary, vpn[27:22]};
  end
endmodule

// File: rtl/hpw_perm.sv
// Protection decision and referenced/changed update for a hit entry.
module hpw_perm
  import hpw_pkg::*;
(
  input  logic [31:0] pte_lo,
  input  logic        is_store,
  input  logic        is_fetch,
  output logic        prot_fault,
  output logic [31:0] new_word
);
  always_comb begin
    prot_fault = (is_fetch && (pte_lo & BIT_GUARD) != 0) ||
                 (is_store && pte_lo[1:0] == 2'b11);
    new_word   = pte_lo | BIT_REF | (is_store ? BIT_CHG : 32'd0);
  end
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
  import hpw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  parameter int ENTRY_BYTES   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] table_cfg,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_ea,
  input  logic        req_store,
  input  logic        req_fetch,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_pa,
  output logic [31:0] rsp_status,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  localparam int IDX_W = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);
  localparam logic [31:0] WORD2_OFF = 32'd4;

  walk_state_t      state;
  logic [31:0]      ea_q, cfg_q, wb_q, pa_q, status_q;
  logic             store_q, fetch_q, pass_q, fault_q;
  logic [IDX_W-1:0] idx_q;

  logic [31:0] entry_addr, cmp_word, new_word;
  logic        prot_fault, mem_done;

  hpw_hash #(.IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_hash (
    .vpn        (ea_q[31:12]),
    .cfg        (cfg_q),
    .secondary  (pass_q),
    .idx        (idx_q),
    .entry_addr (entry_addr),
    .cmp_word   (cmp_word)
  );

  hpw_perm u_perm (
    .pte_lo     (mem_rdata),
    .is_store   (store_q),
    .is_fetch   (fetch_q),
    .prot_fault (prot_fault),
    .new_word   (new_word)
  );

  assign mem_done   = mem_valid && mem_ready;
  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_RESP);
  assign rsp_fault  = fault_q;
  assign rsp_pa     = pa_q;
  assign rsp_status = status_q;
  assign mem_valid  = (state == S_CMP) || (state == S_WORD) || (state == S_WB);
  assign mem_we     = (state == S_WB);
  assign mem_addr   = (state == S_CMP) ? entry_addr : entry_addr + WORD2_OFF;
  assign mem_wdata  = wb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ea_q     <= '0;
      cfg_q    <= '0;
      wb_q     <= '0;
      pa_q     <= '0;
      status_q <= '0;
      store_q  <= 1'b0;
      fetch_q  <= 1'b0;
      pass_q   <= 1'b0;
      fault_q  <= 1'b0;
      idx_q    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          ea_q     <= req_ea;
          cfg_q    <= table_cfg;
          store_q  <= req_store;
          fetch_q  <= req_fetch;
          pass_q   <= 1'b0;
          idx_q    <= '0;
          fault_q  <= 1'b0;
          status_q <= '0;
          pa_q     <= '0;
          state    <= S_CMP;
        end
        S_CMP: if (mem_done) begin
          if (mem_rdata == cmp_word) begin
            state <= S_WORD;
          end else if (idx_q != LAST_IDX) begin
            idx_q <= idx_q + 1'b1;
          end else if (!pass_q) begin
            pass_q <= 1'b1;
            idx_q  <= '0;
          end else begin
            fault_q  <= 1'b1;
            status_q <= ST_NOTFOUND | (store_q ? ST_STORE : 32'd0);
            state    <= S_RESP;
          end
        end
        S_WORD: if (mem_done) begin
          if (prot_fault) begin
            fault_q  <= 1'b1;
            status_q <= ST_PROT | (store_q ? ST_STORE : 32'd0);
            state    <= S_RESP;
          end else begin
            wb_q  <= new_word;
            pa_q  <= {mem_rdata[31:12], ea_q[11:0]};
            state <= S_WB;
          end
        end
        S_WB: if (mem_done) state <= S_RESP;
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpw_walker_chk.sv
module hpw_walker_chk
  import hpw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] rsp_status,
  input logic        mem_valid,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready
);
  p_accept_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_busy_until_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_valid) |=> !req_ready);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ok_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_status == 32'd0);

  p_one_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> $countones(rsp_status & (ST_NOTFOUND | ST_PROT)) == 1);

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);

  p_wb_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_wdata & BIT_REF) != 32'd0);
endmodule

bind hpw_walker hpw_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_status (rsp_status),
  .mem_valid  (mem_valid),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready)
);

// File: tb/tb_hpw_walker.sv
`timescale 1ns/1ps
module tb_hpw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] table_cfg = 32'h0001_0000;
  logic        req_valid = 1'b0, req_store = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_ea = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_pa, rsp_status;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] first_rd;
  logic [31:0] mem [logic [31:0]];
  logic        got_fault;
  logic [31:0] got_pa, got_status;

  always #5 clk = ~clk;

  hpw_walker dut (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mem_ready <= 1'b0;
    else if (mem_valid && !mem_ready) begin
      mem_ready <= 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        n_wr++;
      end else begin
        mem_rdata <= rd(mem_addr);
        if (n_rd == 0) first_rd = mem_addr;
        n_rd++;
      end
    end else mem_ready <= 1'b0;
  end

  // Expected group base from R1/R3/R12
  function automatic logic [31:0] grp(input logic [31:0] ea, input logic [31:0] cfg, input bit sec);
    logic [31:0] h, m;
    h = ((ea >> 12) & 32'hFFFF) ^ (ea >> 28);
    if (sec) h = ~h;
    h = h & 32'h7FFFF;
    m = ((cfg & 32'h1FF) << 16) | 32'hFFC0;
    return (cfg & ~32'h1FF) | ((h << 6) & m);
  endfunction

  function automatic logic [31:0] cmpw(input logic [31:0] ea, input bit sec);
    return 32'h8000_0000 | ((ea >> 28) << 7) | (sec ? 32'h40 : 32'h0) | ((ea >> 22) & 32'h3F);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] ea, input bit sec, input int i, input logic [31:0] cw, input logic [31:0] w2);
    logic [31:0] a;
    a = grp(ea, table_cfg, sec) + 32'(i * 8);
    mem[a] = cw;
    mem[a + 4] = w2;
  endtask

  task automatic translate(input logic [31:0] ea, input bit st, input bit fe);
    int t;
    bit busy_bad;
    busy_bad = 1'b0;
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_ea = ea; req_store = st; req_fetch = fe; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 2000) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      t++;
    end
    check(t < 2000, "R10 response timeout", 32'(t), 32'd2000);
    check(!busy_bad, "R10 req_ready low while busy", {31'd0, busy_bad}, 32'd0);
    got_fault = rsp_fault; got_pa = rsp_pa; got_status = rsp_status;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R10 single response pulse", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R10 reset ready", {31'd0, req_ready}, 32'd1);
    check(!rsp_valid && !mem_valid, "R11 reset quiet", {30'd0, rsp_valid, mem_valid}, 32'd0);
  endtask

  task automatic t_primary_load();
    logic [31:0] ea = 32'h1234_5678;
    mem.delete();
    put(ea, 0, 0, cmpw(ea, 0), 32'hABCD_E012);
    translate(ea, 0, 0);
    check(first_rd == grp(ea, table_cfg, 0), "R1 first read at primary group", first_rd, grp(ea, table_cfg, 0));
    check(n_rd == 2 && n_wr == 1, "R1 reads for entry 0 hit", 32'(n_rd), 32'd2);
    check(!got_fault && got_pa == 32'hABCD_E678, "R6 physical address", got_pa, 32'hABCD_E678);
    check(got_status == 0, "R6 status zero", got_status, 32'd0);
    check(rd(grp(ea, table_cfg, 0) + 4) == 32'hABCD_E112, "R5 referenced bit on load", rd(grp(ea, table_cfg, 0) + 4), 32'hABCD_E112);
  endtask

  task automatic t_store_decoy();
    logic [31:0] ea = 32'h7001_F004;
    mem.delete();
    put(ea, 0, 1, cmpw(ea, 1), 32'h1111_1000);
    put(ea, 0, 3, cmpw(ea, 0) & 32'h7FFF_FFFF, 32'h2222_2000);
    put(ea, 0, 5, cmpw(ea, 0), 32'h3333_3002);
    translate(ea, 1, 0);
    check(!got_fault && got_pa == 32'h3333_3004, "R2 match ignores H-set and invalid decoys", got_pa, 32'h3333_3004);
    check(n_rd == 7, "R2 reads up to entry 5", 32'(n_rd), 32'd7);
    check(rd(grp(ea, table_cfg, 0) + 44) == 32'h3333_3182, "R5 referenced and changed on store", rd(grp(ea, table_cfg, 0) + 44), 32'h3333_3182);
  endtask

  task automatic t_first_match();
    logic [31:0] ea = 32'h0040_2ABC;
    mem.delete();
    put(ea, 0, 1, cmpw(ea, 0), 32'h0AAA_A000);
    put(ea, 0, 4, cmpw(ea, 0), 32'h0BBB_B000);
    translate(ea, 0, 0);
    check(got_pa == 32'h0AAA_AABC, "R2 lowest matching entry wins", got_pa, 32'h0AAA_AABC);
    check(rd(grp(ea, table_cfg, 0) + 36) == 32'h0BBB_B000, "R2 later match untouched", rd(grp(ea, table_cfg, 0) + 36), 32'h0BBB_B000);
  endtask

  task automatic t_secondary();
    logic [31:0] ea = 32'hC0FF_E123;
    mem.delete();
    for (int i = 0; i < 8; i++) put(ea, 0, i, cmpw(ea, 0) ^ 32'h1, 32'h0);
    put(ea, 1, 3, cmpw(ea, 1), 32'h5555_5000);
    translate(ea, 0, 0);
    check(!got_fault && got_pa == 32'h5555_5123, "R3 secondary hit address", got_pa, 32'h5555_5123);
    check(n_rd == 13, "R3 eight primary plus four secondary reads", 32'(n_rd), 32'd13);
    check(rd(grp(ea, table_cfg, 1) + 28) == 32'h5555_5100, "R3 secondary entry written back", rd(grp(ea, table_cfg, 1) + 28), 32'h5555_5100);
  endtask

  task automatic t_notfound();
    logic [31:0] ea = 32'h89AB_C000;
    mem.delete();
    put(ea, 1, 2, cmpw(ea, 0), 32'h0);
    translate(ea, 0, 0);
    check(got_fault && got_status == 32'h4000_0000, "R4 not-found status", got_status, 32'h4000_0000);
    check(n_rd == 16 && n_wr == 0, "R4 sixteen reads, no write", 32'(n_rd * 16 + n_wr), 32'd256);
    translate(ea, 1, 0);
    check(got_fault && got_status == 32'h4200_0000, "R9 store not-found status", got_status, 32'h4200_0000);
  endtask

  task automatic t_guard();
    logic [31:0] ea = 32'h2000_4010;
    mem.delete();
    put(ea, 0, 0, cmpw(ea, 0), 32'h6666_6008);
    translate(ea, 0, 1);
    check(got_fault && got_status == 32'h0800_0000, "R7 guarded fetch fault", got_status, 32'h0800_0000);
    check(n_wr == 0 && rd(grp(ea, table_cfg, 0) + 4) == 32'h6666_6008, "R7 no writeback", rd(grp(ea, table_cfg, 0) + 4), 32'h6666_6008);
    translate(ea, 0, 0);
    check(!got_fault && got_pa == 32'h6666_6010, "R7 load from guarded page allowed", got_pa, 32'h6666_6010);
  endtask

  task automatic t_readonly();
    logic [31:0] ea = 32'h3003_0FF0;
    mem.delete();
    put(ea, 0, 6, cmpw(ea, 0), 32'h7777_7003);
    translate(ea, 1, 0);
    check(got_fault && got_status == 32'h0A00_0000, "R8 R9 store to read-only", got_status, 32'h0A00_0000);
    check(n_wr == 0, "R8 no write on protection fault", 32'(n_wr), 32'd0);
    translate(ea, 0, 0);
    check(!got_fault && got_pa == 32'h7777_7FF0, "R8 load from read-only allowed", got_pa, 32'h7777_7FF0);
  endtask

  task automatic t_size();
    logic [31:0] ea = 32'h0040_0000;
    mem.delete();
    table_cfg = 32'h0010_0001;
    put(ea, 0, 0, cmpw(ea, 0), 32'h4444_4000);
    translate(ea, 0, 0);
    check(first_rd == 32'h0011_0000, "R12 size field widens group index", first_rd, 32'h0011_0000);
    check(!got_fault && got_pa == 32'h4444_4000, "R12 hit in widened table", got_pa, 32'h4444_4000);
    table_cfg = 32'h0001_0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary_load();
    t_store_decoy();
    t_first_match();
    t_secondary();
    t_notfound();
    t_guard();
    t_readonly();
    t_size();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule